// File: doc/BRIEF.md
# DMA Channel Flag Clear Unit

This block keeps two per-channel status vectors for a DMA controller with `NUM_CH` channels (16 by default). The first vector holds the interrupt request flags, one per channel, and drives the interrupt request lines. The second vector holds the error-interrupt enables. Hardware raises bits in either vector with one-cycle set pulses. Software lowers them through two byte-wide, write-only command registers, one command register for each vector.

Software writes one byte to a command register, and the low 7 bits of that byte form the command value. A value below the channel count clears the bit of that one channel. A value from the channel count up to 63 is reserved and changes nothing. A value of 64 or more has its top bit set and clears the whole vector in one write. Both vectors can be read back at two read-only status addresses. A read of either command word returns zero.

Top module: `dma_flag_clear`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset is released, both `irq_req` and `err_irq_en` read as all zeros.
- R2: A write to word address 0x1C with `wr_be[0]` set uses `wr_data[7:0]` as the interrupt command byte. When the low 7 bits of that byte hold a value n below 16, only bit n of `irq_req` is cleared.
- R3: A write to word address 0x18 with `wr_be[3]` set uses `wr_data[31:24]` as the error-enable command byte (byte offset 0x1B). When the low 7 bits of that byte hold a value n below 16, only bit n of `err_irq_en` is cleared.
- R4: A command value from 16 to 63 leaves the target vector unchanged.
- R5: A command value from 64 to 127 (bit 6 of the byte set) clears every bit of the target vector. The other vector is not affected.
- R6: Bit 7 of a command byte is reserved. The command value comes from bits 6:0 alone, so 0x82 acts exactly like 0x02.
- R7: A write whose byte lane for a command offset is disabled, or a write to any other word address, changes neither vector.
- R8: A pulse on bit i of `irq_set` or `err_set` makes that bit read 1 on the next cycle. This holds even when a command clears the same bit in the same cycle.
- R9: A read with `rd_addr` = 0x20 returns `err_irq_en` in `rd_data[15:0]`, and a read with `rd_addr` = 0x24 returns `irq_req` in `rd_data[15:0]`. Reads of the command words 0x18 and 0x1C, and of every other address, return zero. The data is combinational when `RD_PIPE` is 0.
- R10: A command takes effect on the rising clock edge that samples the write. Before that edge the vectors keep their old values, and from the cycle after it they hold the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Word-aligned byte address of the write |
| wr_be | input | BUS_BYTES | Byte-lane enables; lane k carries bits 8k+7:8k |
| wr_data | input | 8*BUS_BYTES | Write data |
| rd_addr | input | ADDR_W | Word-aligned byte address of the read |
| rd_data | output | 8*BUS_BYTES | Read data |
| irq_set | input | NUM_CH | Hardware set pulses for the interrupt request flags |
| err_set | input | NUM_CH | Hardware set pulses for the error-interrupt enables |
| irq_req | output | NUM_CH | Interrupt request flags, one per channel |
| err_irq_en | output | NUM_CH | Error-interrupt enables, one per channel |

## Verification
The hardest case to reach is a hardware set pulse and a software clear that land on the same bit at the same clock edge, because the two come from unrelated sources. The bench drives the command write and the set pulse in the same driver call, so both are sampled at one edge. It does this for a single-channel clear and again for a global clear. The reserved-bit and byte-lane cases are also driven directly: the bench writes command bytes with bit 7 set, and issues writes that carry a valid command value but have the wrong lane enabled or go to the wrong word.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_ONE  = 2'd1,
      CMD_RSVD = 2'd2,
      CMD_ALL  = 2'd3
   } cmd_kind_e;

endpackage

// File: rtl/dfc_cmd_port.sv
module dfc_cmd_port #(
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned BUS_BYTES = 4,
   parameter int unsigned CMD_OFS   = 28,
   parameter int unsigned CMD_W     = 7
) (
   input  logic                                   wr_en,
   input  logic [ADDR_W-1:0]                      wr_addr,
   input  logic [BUS_BYTES-1:0]                   wr_be,
   input  logic [dfc_pkg::BYTE_W*BUS_BYTES-1:0]   wr_data,
   output logic                                   hit_o,
   output logic [CMD_W-1:0]                       val_o
);
   import dfc_pkg::*;

   localparam int unsigned DATA_W = BYTE_W * BUS_BYTES;
   localparam int unsigned LANE   = CMD_OFS % BUS_BYTES;
   localparam logic [ADDR_W-1:0] WORD_ADDR = ADDR_W'(CMD_OFS - LANE);

   if (CMD_W < 2 || CMD_W > BYTE_W) begin : g_bad_cmd_w
      $error("dfc_cmd_port: CMD_W must lie between 2 and 8");
   end
   if (CMD_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
      $error("dfc_cmd_port: CMD_OFS does not fit in ADDR_W");
   end

   logic [BYTE_W-1:0] lane_byte;
   logic              unused_rest;

   // the command byte sits in the lane that matches the low address bits
   assign lane_byte   = wr_data[LANE*BYTE_W +: BYTE_W];
   assign hit_o       = wr_en && (wr_addr == WORD_ADDR) && wr_be[LANE];
   // bits above the command field are reserved and dropped here
   assign val_o       = lane_byte[CMD_W-1:0];
   assign unused_rest = ^{wr_data, lane_byte};

endmodule

// File: rtl/dfc_cmd_decode.sv
module dfc_cmd_decode #(
   parameter int unsigned NUM_CH = 16,
   parameter int unsigned CMD_W  = 7
) (
   input  logic                hit_i,
   input  logic [CMD_W-1:0]    val_i,
   output dfc_pkg::cmd_kind_e  kind_o,
   output logic [NUM_CH-1:0]   clr_o
);
   import dfc_pkg::*;

   localparam int unsigned IDX_W = CMD_W - 1;

   if (NUM_CH < 1 || NUM_CH > (1 << IDX_W)) begin : g_bad_num_ch
      $error("dfc_cmd_decode: NUM_CH must fit in the index field");
   end

   logic [IDX_W-1:0] idx;
   assign idx = val_i[IDX_W-1:0];

   // the top bit of the command selects the global clear
   always_comb begin
      if (!hit_i) begin
         kind_o = CMD_NONE;
      end else if (val_i[CMD_W-1]) begin
         kind_o = CMD_ALL;
      end else if (32'(idx) < 32'(NUM_CH)) begin
         kind_o = CMD_ONE;
      end else begin
         kind_o = CMD_RSVD;
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_clr
      assign clr_o[i] = (kind_o == CMD_ALL) ||
                        ((kind_o == CMD_ONE) && (idx == IDX_W'(i)));
   end

endmodule

// File: rtl/dfc_flag_vec.sv
module dfc_flag_vec #(
   parameter int unsigned NUM_CH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_i,
   input  logic [NUM_CH-1:0] clr_i,
   output logic [NUM_CH-1:0] vec_o
);

   // a set pulse wins over a clear of the same bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_o <= '0;
      end else begin
         vec_o <= (vec_o & ~clr_i) | set_i;
      end
   end

   // R8: every pulsed bit reads 1 on the next cycle
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((vec_o & $past(set_i)) == $past(set_i)));

   // R10: with no set and no clear the vector holds
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0 && clr_i == '0) |=> $stable(vec_o));

endmodule

// File: rtl/dfc_rd_mux.sv
module dfc_rd_mux #(
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned BUS_BYTES = 4,
   parameter int unsigned NUM_CH    = 16,
   parameter int unsigned ERR_OFS   = 32,
   parameter int unsigned IRQ_OFS   = 36,
   parameter bit          RD_PIPE   = 1'b0
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [ADDR_W-1:0]                     rd_addr,
   input  logic [NUM_CH-1:0]                     err_i,
   input  logic [NUM_CH-1:0]                     irq_i,
   output logic [dfc_pkg::BYTE_W*BUS_BYTES-1:0]  rd_data_o
);
   import dfc_pkg::*;

   localparam int unsigned DATA_W = BYTE_W * BUS_BYTES;

   if (NUM_CH > DATA_W) begin : g_bad_width
      $error("dfc_rd_mux: NUM_CH wider than the read bus");
   end
   if ((ERR_OFS % BUS_BYTES) != 0 || (IRQ_OFS % BUS_BYTES) != 0) begin : g_bad_align
      $error("dfc_rd_mux: status offsets must be word aligned");
   end

   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      if (rd_addr == ADDR_W'(ERR_OFS)) begin
         sel = DATA_W'(err_i);
      end else if (rd_addr == ADDR_W'(IRQ_OFS)) begin
         sel = DATA_W'(irq_i);
      end
   end

   if (RD_PIPE) begin : g_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_q <= '0;
         end else begin
            rd_q <= sel;
         end
      end
      assign rd_data_o = rd_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk & rst_n;
      assign rd_data_o  = sel;
   end

endmodule

// File: rtl/dma_flag_clear.sv
module dma_flag_clear #(
   parameter int unsigned NUM_CH      = 16,
   parameter int unsigned CMD_W       = 7,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned BUS_BYTES   = 4,
   parameter int unsigned IRQ_CMD_OFS = 28,
   parameter int unsigned ERR_CMD_OFS = 27,
   parameter int unsigned ERR_RD_OFS  = 32,
   parameter int unsigned IRQ_RD_OFS  = 36,
   parameter bit          RD_PIPE     = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [BUS_BYTES-1:0]   wr_be,
   input  logic [8*BUS_BYTES-1:0] wr_data,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [8*BUS_BYTES-1:0] rd_data,
   input  logic [NUM_CH-1:0]      irq_set,
   input  logic [NUM_CH-1:0]      err_set,
   output logic [NUM_CH-1:0]      irq_req,
   output logic [NUM_CH-1:0]      err_irq_en
);
   import dfc_pkg::*;

   localparam int unsigned IDX_W = CMD_W - 1;
   localparam logic [ADDR_W-1:0] IRQ_CMD_WORD =
      ADDR_W'(IRQ_CMD_OFS - (IRQ_CMD_OFS % BUS_BYTES));
   localparam logic [ADDR_W-1:0] ERR_CMD_WORD =
      ADDR_W'(ERR_CMD_OFS - (ERR_CMD_OFS % BUS_BYTES));

   if (IRQ_CMD_OFS == ERR_CMD_OFS) begin : g_bad_cmd_ofs
      $error("dma_flag_clear: command offsets must differ");
   end
   if (ERR_RD_OFS == IRQ_RD_OFS) begin : g_bad_rd_ofs
      $error("dma_flag_clear: status offsets must differ");
   end

   logic              irq_hit, err_hit;
   logic [CMD_W-1:0]  irq_val, err_val;
   cmd_kind_e         irq_kind, err_kind;
   logic [NUM_CH-1:0] irq_clr, err_clr;

   dfc_cmd_port #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES),
                  .CMD_OFS(IRQ_CMD_OFS), .CMD_W(CMD_W)) i_irq_port (
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
      .hit_o(irq_hit), .val_o(irq_val));

   dfc_cmd_port #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES),
                  .CMD_OFS(ERR_CMD_OFS), .CMD_W(CMD_W)) i_err_port (
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
      .hit_o(err_hit), .val_o(err_val));

   dfc_cmd_decode #(.NUM_CH(NUM_CH), .CMD_W(CMD_W)) i_irq_dec (
      .hit_i(irq_hit), .val_i(irq_val), .kind_o(irq_kind), .clr_o(irq_clr));

   dfc_cmd_decode #(.NUM_CH(NUM_CH), .CMD_W(CMD_W)) i_err_dec (
      .hit_i(err_hit), .val_i(err_val), .kind_o(err_kind), .clr_o(err_clr));

   dfc_flag_vec #(.NUM_CH(NUM_CH)) i_irq_vec (
      .clk(clk), .rst_n(rst_n), .set_i(irq_set), .clr_i(irq_clr), .vec_o(irq_req));

   dfc_flag_vec #(.NUM_CH(NUM_CH)) i_err_vec (
      .clk(clk), .rst_n(rst_n), .set_i(err_set), .clr_i(err_clr), .vec_o(err_irq_en));

   dfc_rd_mux #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .NUM_CH(NUM_CH),
                .ERR_OFS(ERR_RD_OFS), .IRQ_OFS(IRQ_RD_OFS), .RD_PIPE(RD_PIPE)) i_rd (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .err_i(err_irq_en),
      .irq_i(irq_req), .rd_data_o(rd_data));

   // R2: one interrupt flag cleared, all others kept
   a_r2_irq_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_kind == CMD_ONE && irq_set == '0) |=>
      (irq_req == ($past(irq_req) & ~(NUM_CH'(1) << $past(irq_val[IDX_W-1:0])))));

   // R3: one error enable cleared, all others kept
   a_r3_err_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (err_kind == CMD_ONE && err_set == '0) |=>
      (err_irq_en == ($past(err_irq_en) & ~(NUM_CH'(1) << $past(err_val[IDX_W-1:0])))));

   // R4: reserved command values change nothing
   a_r4_rsvd_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_kind == CMD_RSVD && irq_set == '0) |=> $stable(irq_req));

   // R5: global clear leaves only bits set in the same cycle
   a_r5_global_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (err_kind == CMD_ALL) |=> ((err_irq_en & ~$past(err_set)) == '0));

   // R7: writes that miss the command lane leave the vector alone
   a_r7_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_kind == CMD_NONE && irq_set == '0) |=> $stable(irq_req));

   if (!RD_PIPE) begin : g_rd_chk
      // R9: command words read as zero
      a_r9_cmd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_addr == IRQ_CMD_WORD || rd_addr == ERR_CMD_WORD) |-> (rd_data == '0));
   end

endmodule

// File: tb/test_dma_flag_clear.sv
`timescale 1ns/1ps
module test_dma_flag_clear;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_addr = '0;
   logic [3:0]  wr_be = '0;
   logic [31:0] wr_data = '0;
   logic [5:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [15:0] irq_set = '0;
   logic [15:0] err_set = '0;
   logic [15:0] irq_req;
   logic [15:0] err_irq_en;

   dma_flag_clear i_dma_flag_clear (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_set(irq_set),
      .err_set(err_set), .irq_req(irq_req), .err_irq_en(err_irq_en));

   always #10 clk = ~clk;

   typedef struct {
      logic [15:0] irq;
      logic [15:0] err;
      string       tag;
      int          due;
   } exp_t;

   exp_t        q[$];
   exp_t        mon_it;
   int          cyc = 0;
   int          n_chk = 0;
   int          n_err = 0;
   bit          done = 1'b0;
   logic [15:0] m_irq = '0;
   logic [15:0] m_err = '0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] clr_of(input logic [7:0] b);
      logic [6:0] v;
      v = b[6:0];
      if (v[6]) return 16'hFFFF;
      if (v < 7'd16) return 16'h1 << v[3:0];
      return 16'h0;
   endfunction

   // driver: one write and/or set pulse per call, expected state queued
   task automatic op(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d,
                     input logic [15:0] is, input logic [15:0] es, input string tag,
                     input bit pre_chk = 1'b0);
      logic [15:0] ic, ec;
      exp_t it;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
      irq_set = is; err_set = es;
      ic = (a == 6'h1C && be[0]) ? clr_of(d[7:0])   : 16'h0;
      ec = (a == 6'h18 && be[3]) ? clr_of(d[31:24]) : 16'h0;
      if (pre_chk) begin
         #1;
         chk(irq_req == m_irq, "R10", "irq before edge", {16'h0, irq_req}, {16'h0, m_irq});
      end
      m_irq = (m_irq & ~ic) | is;
      m_err = (m_err & ~ec) | es;
      it.irq = m_irq; it.err = m_err; it.tag = tag; it.due = cyc + 1;
      q.push_back(it);
      @(negedge clk);
      wr_en = 1'b0; wr_be = '0; irq_set = '0; err_set = '0;
   endtask

   task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string what);
      @(negedge clk);
      rd_addr = a;
      #1;
      chk(rd_data == exp, "R9", what, rd_data, exp);
   endtask

   // monitor: compare the outputs once the queued item is due
   always @(negedge clk) begin
      if (q.size() > 0 && q[0].due <= cyc) begin
         mon_it = q.pop_front();
         chk(irq_req == mon_it.irq, mon_it.tag, "irq_req", {16'h0, irq_req}, {16'h0, mon_it.irq});
         chk(err_irq_en == mon_it.err, mon_it.tag, "err_irq_en",
             {16'h0, err_irq_en}, {16'h0, mon_it.err});
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(irq_req == 16'h0 && err_irq_en == 16'h0, "R1", "in reset",
          {irq_req, err_irq_en}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(irq_req == 16'h0 && err_irq_en == 16'h0, "R1", "after reset",
          {irq_req, err_irq_en}, 32'h0);

      op(6'h00, 4'h0, 32'h0, 16'hFFFF, 16'hFFFF, "R8 set all");
      op(6'h1C, 4'h1, 32'h05, 16'h0, 16'h0, "R2 idx5", 1'b1);
      op(6'h1C, 4'h1, 32'h00, 16'h0, 16'h0, "R2 idx0");
      op(6'h1C, 4'h1, 32'h0F, 16'h0, 16'h0, "R2 idx15");
      op(6'h18, 4'h8, 32'h03000000, 16'h0, 16'h0, "R3 idx3");
      op(6'h18, 4'h8, 32'h0F000000, 16'h0, 16'h0, "R3 idx15");
      op(6'h1C, 4'h1, 32'h10, 16'h0, 16'h0, "R4 val16");
      op(6'h1C, 4'h1, 32'h28, 16'h0, 16'h0, "R4 val40");
      op(6'h18, 4'h8, 32'h3F000000, 16'h0, 16'h0, "R4 val63");
      op(6'h1C, 4'h1, 32'h82, 16'h0, 16'h0, "R6 irq 0x82");
      op(6'h18, 4'h8, 32'h8B000000, 16'h0, 16'h0, "R6 err 0x8B");
      op(6'h1C, 4'hE, 32'h04040404, 16'h0, 16'h0, "R7 lane off");
      op(6'h18, 4'h7, 32'h04040404, 16'h0, 16'h0, "R7 err lane off");
      op(6'h20, 4'hF, 32'h04040404, 16'h0, 16'h0, "R7 other word");
      op(6'h1C, 4'h1, 32'h05, 16'h0020, 16'h0, "R8 set vs one clear");
      rd_chk(6'h1C, 32'h0, "irq command word");
      rd_chk(6'h18, 32'h0, "err command word");
      rd_chk(6'h20, {16'h0, m_err}, "err status");
      rd_chk(6'h24, {16'h0, m_irq}, "irq status");
      rd_chk(6'h3C, 32'h0, "unmapped word");
      op(6'h1C, 4'h1, 32'h40, 16'h0, 16'h0, "R5 irq global 64");
      op(6'h00, 4'h0, 32'h0, 16'h00F0, 16'h0, "R8 refill");
      op(6'h1C, 4'h1, 32'h40, 16'h0100, 16'h0, "R8 set vs global");
      op(6'h18, 4'h8, 32'h7F000000, 16'h0, 16'h0, "R5 err global 127");
      rd_chk(6'h24, {16'h0, m_irq}, "irq status after global");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule